// File: doc/BRIEF.md
# Symbol Pair Framer and Decoder

This block sits in the receive path of a ring-network physical layer, after clock recovery and rate matching. It takes a stream of 5-bit line code symbols, each marked by a valid strobe. Until it finds a start delimiter it produces no output. The start delimiter is a J symbol followed directly by a K symbol. After that it groups the accepted symbols two at a time, decodes each symbol into a 5-bit half-word, and presents the pair as a registered 10-bit word with a one-cycle strobe.

Every J-K delimiter re-establishes the pairing, including one whose J landed in the second slot of a pair. The delimiter is then still delivered as a word of its own.

Each half-word carries a control flag in its top bit and a 4-bit value below it. Two status inputs come from the upstream rate-matching stage. When both are high, they override the decode of a symbol and mark it as an invalid-PHY half. This override takes precedence over the violation marking for unrecognised codes.

Top module: `sym_pair_framer`

## Requirements
- R1: While rst_ni is low and after its release, byte_valid_o is 0 and byte_o is 10'h000 until the first word is produced.
- R2: Before the first J-K delimiter has been accepted, byte_valid_o stays 0 whatever symbols arrive, including a K before a J and a J followed by any symbol other than K.
- R3: An accepted J (5'b11000) whose next accepted symbol is K (5'b10001) produces, on the cycle after the K is accepted, byte_valid_o=1 with byte_o=10'h253 (high half 5'h12, low half 5'h13).
- R4: After a delimiter, later accepted symbols are grouped two at a time. The earlier symbol goes in byte_o[9:5] and the later in byte_o[4:0]. byte_valid_o is high for exactly the one cycle after the second symbol of a pair is accepted.
- R5: The data codes decode to half {1'b0, value}: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F.
- R6: The control codes decode to half {1'b1, value}: 00000 (quiet)=0, 00100 (halt)=1, 11000 (J)=2, 10001 (K)=3, 01101 (T)=4, 00111 (R)=5, 11001 (S)=6, 11111 (idle)=7.
- R7: Any other 5-bit code decodes to the violation half 5'h1E.
- R8: A symbol accepted while eb_err_i and quiet_i are both 1 decodes to the invalid-PHY half 5'h1F, whatever its code, violations included. Either input alone has no effect on the decode.
- R9: When a J is the second symbol of a pair and the next accepted symbol is K, the word holding the J is emitted as normal. After the K, the word {J,K}=10'h253 is emitted too, and the next accepted symbol starts a new pair.
- R10: Cycles with sym_valid_i=0 are ignored. They neither count toward pairing nor break a J-K delimiter, whatever sym_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 5 | Received line code symbol |
| sym_valid_i | input | 1 | sym_i carries a symbol this cycle |
| eb_err_i | input | 1 | Rate-matching buffer overflow/underflow flag |
| quiet_i | input | 1 | Line currently in the quiet state |
| byte_o | output | 10 | Decoded pair: {ctl_hi, val_hi, ctl_lo, val_lo} |
| byte_valid_o | output | 1 | byte_o holds a new pair this cycle |

## Verification
A wrong pairing phase shows at the ports on the next word as swapped or shifted halves. It also shows as a strobe that arrives one accepted symbol early or late. A stale lock flag shows as a strobe before any delimiter, or as silence after one, on the cycle after the second symbol. A lost last-symbol register breaks a delimiter that crosses a pair or a gap, so the 10'h253 word does not appear one cycle after the K. Decode and precedence faults appear in the very word that carries the affected symbol.

// File: rtl/sp_frame_pkg.sv
package sp_frame_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;
  localparam int HALF_W = NIB_W + 1;
  localparam int WORD_W = 2 * HALF_W;

  typedef struct packed {
    logic             ctl;
    logic [NIB_W-1:0] val;
  } half_t;

  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

  localparam half_t HALF_VIOL   = '{ctl: 1'b1, val: 4'hE};
  localparam half_t HALF_PHYINV = '{ctl: 1'b1, val: 4'hF};
endpackage

// File: rtl/sp_sym_decoder.sv
module sp_sym_decoder
  import sp_frame_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  input  logic             eb_err_i,
  input  logic             quiet_i,
  output half_t            half_o
);
  half_t dec;

  always_comb begin
    dec = HALF_VIOL;
    unique case (sym_i)
      5'b11110: dec = '{1'b0, 4'h0};
      5'b01001: dec = '{1'b0, 4'h1};
      5'b10100: dec = '{1'b0, 4'h2};
      5'b10101: dec = '{1'b0, 4'h3};
      5'b01010: dec = '{1'b0, 4'h4};
      5'b01011: dec = '{1'b0, 4'h5};
      5'b01110: dec = '{1'b0, 4'h6};
      5'b01111: dec = '{1'b0, 4'h7};
      5'b10010: dec = '{1'b0, 4'h8};
      5'b10011: dec = '{1'b0, 4'h9};
      5'b10110: dec = '{1'b0, 4'hA};
      5'b10111: dec = '{1'b0, 4'hB};
      5'b11010: dec = '{1'b0, 4'hC};
      5'b11011: dec = '{1'b0, 4'hD};
      5'b11100: dec = '{1'b0, 4'hE};
      5'b11101: dec = '{1'b0, 4'hF};
      5'b00000: dec = '{1'b1, 4'h0};
      5'b00100: dec = '{1'b1, 4'h1};
      5'b11000: dec = '{1'b1, 4'h2};
      5'b10001: dec = '{1'b1, 4'h3};
      5'b01101: dec = '{1'b1, 4'h4};
      5'b00111: dec = '{1'b1, 4'h5};
      5'b11001: dec = '{1'b1, 4'h6};
      5'b11111: dec = '{1'b1, 4'h7};
      default:  dec = HALF_VIOL;
    endcase
  end

  // invalid-PHY beats violation and normal decode
  assign half_o = (eb_err_i && quiet_i) ? HALF_PHYINV : dec;
endmodule

// File: rtl/sp_delim_detect.sv
module sp_delim_detect
  import sp_frame_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             jk_o
);
  logic [SYM_W-1:0] last_sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_sym_q <= SYM_IDLE;
    else if (acc_i) last_sym_q <= sym_i;
  end

  assign jk_o = acc_i && (last_sym_q == SYM_J) && (sym_i == SYM_K);
endmodule

// File: rtl/sp_pair_align.sv
module sp_pair_align
  import sp_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              jk_i,
  input  half_t             cur_half_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] pair_o
);
  logic  locked_q;
  logic  second_q;   // next accepted symbol completes a pair
  half_t last_half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q    <= 1'b0;
      second_q    <= 1'b0;
      last_half_q <= '0;
    end else if (acc_i) begin
      last_half_q <= cur_half_i;
      if (jk_i) begin
        locked_q <= 1'b1;
        second_q <= 1'b0;
      end else if (locked_q) begin
        second_q <= ~second_q;
      end
    end
  end

  assign emit_o = acc_i && (jk_i || (locked_q && second_q));
  assign pair_o = {last_half_q, cur_half_i};
endmodule

// File: rtl/sym_pair_framer.sv
module sym_pair_framer
  import sp_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              sym_valid_i,
  input  logic              eb_err_i,
  input  logic              quiet_i,
  output logic [WORD_W-1:0] byte_o,
  output logic              byte_valid_o
);
  half_t             cur_half;
  logic              jk;
  logic              emit;
  logic [WORD_W-1:0] pair;

  sp_sym_decoder u_dec (
    .sym_i    (sym_i),
    .eb_err_i (eb_err_i),
    .quiet_i  (quiet_i),
    .half_o   (cur_half)
  );

  sp_delim_detect u_delim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (sym_valid_i),
    .sym_i  (sym_i),
    .jk_o   (jk)
  );

  sp_pair_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (sym_valid_i),
    .jk_i       (jk),
    .cur_half_i (cur_half),
    .emit_o     (emit),
    .pair_o     (pair)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= emit;
      if (emit) byte_o <= pair;
    end
  end
endmodule

// File: rtl/sym_pair_framer_chk.sv
module sym_pair_framer_chk
  import sp_frame_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SYM_W-1:0]  sym_i,
  input logic              sym_valid_i,
  input logic              eb_err_i,
  input logic              quiet_i,
  input logic [WORD_W-1:0] byte_o,
  input logic              byte_valid_o
);
  logic seen_jk_q;
  logic last_j_q;
  logic forced;

  assign forced = eb_err_i && quiet_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_jk_q <= 1'b0;
      last_j_q  <= 1'b0;
    end else if (sym_valid_i) begin
      last_j_q <= (sym_i == SYM_J) && !forced;
      if (last_j_q && sym_i == SYM_K) seen_jk_q <= 1'b1;
    end
  end

  AST_NO_WORD_BEFORE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> seen_jk_q); // R2

  AST_DELIM_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_i == SYM_K && last_j_q && !forced)
      |=> (byte_valid_o && byte_o == 10'h253)); // R3

  AST_WORD_NEEDS_SYMBOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(sym_valid_i)); // R10

  AST_PHYINV_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && forced) |=> (!byte_valid_o || byte_o[HALF_W-1:0] == 5'h1F)); // R8

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (!byte_valid_o || rst_ni)); // R1
endmodule

bind sym_pair_framer sym_pair_framer_chk u_chk (.*);

// File: tb/sym_pair_framer_bench.sv
`timescale 1ns/1ps
module sym_pair_framer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] sym_i = 5'b11111;
  logic       sym_valid_i = 1'b0;
  logic       eb_err_i = 1'b0;
  logic       quiet_i = 1'b0;
  logic [9:0] byte_o;
  logic       byte_valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase_tag = "R2";

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  sym_pair_framer u_sym_pair_framer (.*);

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, I = 5'b11111;
  localparam logic [4:0] Q = 5'b00000, H = 5'b00100, T = 5'b01101;
  localparam logic [4:0] RR = 5'b00111, S = 5'b11001;

  function automatic logic [4:0] hf(input logic [4:0] s);
    case (s)
      5'b11110: return 5'h00; 5'b01001: return 5'h01;
      5'b10100: return 5'h02; 5'b10101: return 5'h03;
      5'b01010: return 5'h04; 5'b01011: return 5'h05;
      5'b01110: return 5'h06; 5'b01111: return 5'h07;
      5'b10010: return 5'h08; 5'b10011: return 5'h09;
      5'b10110: return 5'h0A; 5'b10111: return 5'h0B;
      5'b11010: return 5'h0C; 5'b11011: return 5'h0D;
      5'b11100: return 5'h0E; 5'b11101: return 5'h0F;
      5'b00000: return 5'h10; 5'b00100: return 5'h11;
      5'b11000: return 5'h12; 5'b10001: return 5'h13;
      5'b01101: return 5'h14; 5'b00111: return 5'h15;
      5'b11001: return 5'h16; 5'b11111: return 5'h17;
      default:  return 5'h1E;
    endcase
  endfunction

  function automatic logic [4:0] enc(input int v);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[v];
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic snd(input logic [4:0] s, input logic e = 1'b0, input logic q = 1'b0);
    @(negedge clk_i);
    sym_i = s; sym_valid_i = 1'b1; eb_err_i = e; quiet_i = q;
  endtask

  task automatic gap(input int n, input logic [4:0] s = 5'b11111);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      sym_i = s; sym_valid_i = 1'b0; eb_err_i = 1'b0; quiet_i = 1'b0;
    end
  endtask

  task automatic pr(input logic [4:0] a, input logic [4:0] b, input string tag);
    push({hf(a), hf(b)}, tag);
    snd(a);
    snd(b);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done && byte_valid_o) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL %s: unexpected word actual=%h expected=none", phase_tag, byte_o);
      end else begin
        check(tag_q.pop_front(), byte_o, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset word", byte_o, 10'h000);
    check("R1 reset strobe", {9'b0, byte_valid_o}, 10'h000);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {byte_valid_o, byte_o}, 11'h000);

    // R2 / R10: nothing before a delimiter
    phase_tag = "R2";
    snd(enc(0)); snd(enc(1)); snd(K); snd(J); snd(I); snd(enc(2));
    snd(J); gap(2, K); snd(enc(3));
    gap(3);
    check("R2 no word before lock", {9'b0, byte_valid_o}, 10'h000);

    // R3 delimiter
    phase_tag = "R3";
    push(10'h253, "R3 J-K word");
    snd(J); snd(K);

    // R4/R5 data pairs
    phase_tag = "R4";
    for (int v = 0; v < 16; v += 2) pr(enc(v), enc(v + 1), "R5 data pair R4");

    // R6 control codes
    phase_tag = "R6";
    pr(Q, H, "R6 Q/H"); pr(T, RR, "R6 T/R"); pr(S, I, "R6 S/I");
    pr(K, J, "R6 K/J"); pr(enc(0), enc(7), "R6 after K/J");

    // R7 violations
    phase_tag = "R7";
    pr(5'b00001, 5'b00010, "R7 violation a");
    pr(5'b00011, 5'b00101, "R7 violation b");

    // R8 invalid-PHY precedence
    phase_tag = "R8";
    push({5'h1F, hf(enc(1))}, "R8 forced high half");
    snd(enc(0), 1, 1); snd(enc(1));
    push({hf(enc(2)), hf(enc(3))}, "R8 single flag ignored");
    snd(enc(2), 1, 0); snd(enc(3), 0, 1);
    push(10'h3FF, "R8 over violation");
    snd(5'b00001, 1, 1); snd(I, 1, 1);

    // R9 straddling delimiter
    phase_tag = "R9";
    push({hf(enc(10)), hf(J)}, "R9 pair holding J");
    push(10'h253, "R9 realigned J-K");
    push({hf(enc(12)), hf(enc(13))}, "R9 new pairing");
    snd(enc(10)); snd(J); snd(K); snd(enc(12)); snd(enc(13));

    // R10 gaps
    phase_tag = "R10";
    push({hf(enc(4)), hf(enc(5))}, "R10 pair across gap");
    snd(enc(4)); gap(2); snd(enc(5));
    push({hf(J), hf(enc(5))}, "R10 invalid K ignored");
    snd(J); gap(1, K); snd(enc(5));
    push(10'h253, "R10 J gap K");
    snd(J); gap(3, J); snd(K);
    push({hf(enc(8)), hf(enc(9))}, "R10 after delimiter");
    snd(enc(8)); snd(enc(9));

    gap(4);
    check("R4 all words seen", 10'(exp_q.size()), 10'h000);
    finish_run();
  end
endmodule